// File: doc/BRIEF.md
# Exclusive Access Lock Controller

This block holds the control descriptor of one protected resource, such as a memory region or a peripheral slot, and owns the exclusive-access lock field kept inside one word of that descriptor. The lock is disabled, available, or held by one domain. Software updates the descriptor through a single write port that carries the writing domain's identifier. A write to the lock word with a zero lock field updates the word's other bits. A write with a non-zero lock field changes only the lock, so software can change ownership without rewriting the rest of the configuration.

A domain that does not hold the lock can still return it to the available state. It does this by writing two fixed key values to the lock word back to back. Any write to the descriptor made outside this sequence, and any write at all to a word other than the valid word, clears the descriptor's valid bit. Software must then write the valid word again before the descriptor counts as valid. A combinational read port returns any descriptor word.

Top module: `eal_lock_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, the lock state is disabled (00), the owner is 0, `desc_valid` is 0, every descriptor word reads 0, and the key detector is idle.
- R2: A write to the lock word (index 3) whose lock field (bits [25:24]) is 00 stores all other bits of that word and leaves the lock state and owner unchanged.
- R3: A write to the lock word whose lock field is non-zero leaves the word's other bits unchanged. The lock word reads back its stored bits with the lock state in bits [25:24].
- R4: Lock field values: writing 10 from disabled or available gives available. Writing 10 by the owner while held gives available. Writing 11 from disabled or available gives held, with the writer's domain as owner. Writing 01 has no effect. The state is never 01, and the owner reads 0 whenever the state is not held.
- R5: While the lock is held, a write of 10 or 11 from a domain other than the owner leaves the state and owner unchanged.
- R6: A write of 0x02000046 to the lock word, followed by a write of 0x02000052 to the lock word as the next descriptor write (idle cycles allowed between them), puts the lock in the available state with owner 0, whichever domain writes.
- R7: The key writes never change the non-lock bits of the lock word.
- R8: Any descriptor write between the two keys disarms the detector, and that write is handled as a normal write. A write of 0x02000046 to the lock word always arms the detector, including when it repeats.
- R9: A write of 0x02000052 with no armed detector is a normal write with lock field 10.
- R10: A write to the valid word (index 4) loads `desc_valid` from bit 31. A write to any other descriptor word, key writes included, clears `desc_valid`.
- R11: Words 0 to 2 store whole written words. The valid word reads back its stored bits with `desc_valid` in bit 31. Writes to addresses 5 to 7 are ignored, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_addr | input | ADDR_W (3) | Word index of the write |
| wr_data | input | DATA_W (32) | Write data |
| wr_dom | input | DOM_W (4) | Domain issuing the write |
| rd_addr | input | ADDR_W (3) | Word index to read |
| rd_data | output | DATA_W (32) | Read data, combinational |
| lock_state | output | 2 | Lock state: 00 disabled, 10 available, 11 held |
| lock_owner | output | DOM_W (4) | Owning domain while held, else 0 |
| desc_valid | output | 1 | Descriptor valid bit |

## Verification
The assertions check on every cycle that a zero lock field never moves the lock, and that a non-zero one never touches the other bits. They also check that a foreign domain's plain write cannot take or free a held lock, that a completed key pair always frees it, and how the valid bit follows each write. Only the bench's scenarios can show the ordering rules of the key pair: that a lone second key does nothing, that idle cycles between the keys are allowed, and that an intervening write disarms the detector while a repeated first key keeps it armed. The readback layouts and the ignored out-of-range writes are also shown only by the bench.

// File: rtl/eal_pkg.sv
`timescale 1ns/1ps
// Package: shared lock-state encoding for the exclusive access lock block.
// Assumes a two-bit lock field; 01 is reserved and never held.
package eal_pkg;
    typedef enum logic [1:0] {
        EAL_OFF  = 2'b00,
        EAL_RSVD = 2'b01,
        EAL_FREE = 2'b10,
        EAL_HELD = 2'b11
    } eal_t;
endpackage

// File: rtl/eal_key_detect.sv
`timescale 1ns/1ps
// Module: eal_key_detect
// Watches descriptor writes for the two-word forced-release key pair.
// Assumes wr_hit marks every in-range descriptor write and lock_hit the
// subset aimed at the lock word. Idle cycles do not disturb the detector.
module eal_key_detect #(
    parameter int              DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_A = 32'h0200_0046,
    parameter logic [DATA_W-1:0] KEY_B = 32'h0200_0052
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              lock_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic              force_rel
);
    logic armed_q;

    // Second key completes the pair only when armed and aimed at the lock word.
    assign force_rel = armed_q && wr_hit && lock_hit && (wr_data == KEY_B);

    // Every descriptor write re-decides arming; only a first key arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_hit) begin
            armed_q <= lock_hit && (wr_data == KEY_A);
        end
    end
endmodule

// File: rtl/eal_lock_fsm.sv
`timescale 1ns/1ps
// Module: eal_lock_fsm
// Holds the lock state and owning domain. Applies non-zero lock-field
// writes and the forced release. Assumes req is asserted only for
// writes to the lock word; zero lock-field writes are filtered here.
module eal_lock_fsm
    import eal_pkg::*;
#(
    parameter int DOM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [1:0]       req_eal,
    input  logic [DOM_W-1:0] req_dom,
    input  logic             force_rel,
    output eal_t             state,
    output logic [DOM_W-1:0] owner
);
    eal_t             state_q, state_d;
    logic [DOM_W-1:0] owner_q, owner_d;
    logic             is_owner;

    assign is_owner = (state_q == EAL_HELD) && (req_dom == owner_q);

    // Next-state selection: forced release first, then lock-field writes.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        if (force_rel) begin
            state_d = EAL_FREE;
            owner_d = '0;
        end else if (req) begin
            unique case (req_eal)
                2'b10: begin
                    if (state_q != EAL_HELD || is_owner) begin
                        state_d = EAL_FREE;
                        owner_d = '0;
                    end
                end
                2'b11: begin
                    if (state_q != EAL_HELD) begin
                        state_d = EAL_HELD;
                        owner_d = req_dom;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and owner registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EAL_OFF;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    assign state = state_q;
    assign owner = owner_q;
endmodule

// File: rtl/eal_desc_bank.sv
`timescale 1ns/1ps
// Module: eal_desc_bank
// Descriptor word storage. The plain words take whole writes. The lock
// word keeps its non-lock bits, updated only by zero lock-field writes.
// The valid word keeps its body and the valid flag. Assumes LOCK_WORD
// and VLD_WORD differ and are below NUM_WORDS.
module eal_desc_bank
    import eal_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 5,
    parameter int ADDR_W    = 3,
    parameter int LOCK_WORD = 3,
    parameter int VLD_WORD  = 4,
    parameter int EAL_LSB   = 24,
    parameter int VLD_BIT   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  eal_t              lock_state,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] lock_rest,
    output logic              valid
);
    localparam logic [DATA_W-1:0] EAL_MASK = DATA_W'(2'b11) << EAL_LSB;
    localparam logic [DATA_W-1:0] VLD_MASK = DATA_W'(1'b1) << VLD_BIT;

    logic [DATA_W-1:0] view [NUM_WORDS];
    logic [1:0]        wr_eal;

    assign wr_eal = wr_data[EAL_LSB +: 2];

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
        logic sel;
        assign sel = wr_hit && (wr_addr == IDX);

        if (gi == LOCK_WORD) begin : g_lock
            logic [DATA_W-1:0] rest_q;
            // Non-lock bits change only on a zero lock-field write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rest_q <= '0;
                end else if (sel && (wr_eal == 2'b00)) begin
                    rest_q <= wr_data & ~EAL_MASK;
                end
            end
            assign view[gi]  = rest_q | (DATA_W'(lock_state) << EAL_LSB);
            assign lock_rest = rest_q;
        end else if (gi == VLD_WORD) begin : g_vld
            logic [DATA_W-1:0] body_q;
            logic              vld_q;
            // Valid loads on its own word and drops on any other descriptor write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    body_q <= '0;
                    vld_q  <= 1'b0;
                end else if (sel) begin
                    body_q <= wr_data & ~VLD_MASK;
                    vld_q  <= wr_data[VLD_BIT];
                end else if (wr_hit) begin
                    vld_q  <= 1'b0;
                end
            end
            assign view[gi] = body_q | (DATA_W'(vld_q) << VLD_BIT);
            assign valid    = vld_q;
        end else begin : g_plain
            logic [DATA_W-1:0] word_q;
            // Plain configuration word takes whole writes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (sel) begin
                    word_q <= wr_data;
                end
            end
            assign view[gi] = word_q;
        end
    end

    // Read selection; addresses beyond the descriptor read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = view[i];
            end
        end
    end
endmodule

// File: rtl/eal_lock_ctrl.sv
`timescale 1ns/1ps
// Module: eal_lock_ctrl (top)
// Descriptor register block for one protected resource with an
// exclusive-access lock and a key-pair forced release. Assumes a single
// write per cycle and that the key values carry lock field 10.
module eal_lock_ctrl
    import eal_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter int              NUM_WORDS = 5,
    parameter int              DOM_W     = 4,
    parameter int              LOCK_WORD = 3,
    parameter int              VLD_WORD  = 4,
    parameter int              EAL_LSB   = 24,
    parameter int              VLD_BIT   = 31,
    parameter logic [DATA_W-1:0] KEY_A   = 32'h0200_0046,
    parameter logic [DATA_W-1:0] KEY_B   = 32'h0200_0052,
    localparam int             ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DOM_W-1:0]  wr_dom,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        lock_state,
    output logic [DOM_W-1:0]  lock_owner,
    output logic              desc_valid
);
    logic              wr_hit;
    logic              lock_hit;
    logic              force_rel;
    eal_t              state;
    logic [DATA_W-1:0] lock_rest;

    // Decode in-range writes and those aimed at the lock word.
    assign wr_hit   = wr_en && ({1'b0, wr_addr} < (ADDR_W+1)'(NUM_WORDS));
    assign lock_hit = wr_hit && (wr_addr == ADDR_W'(LOCK_WORD));

    eal_key_detect #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .lock_hit  (lock_hit),
        .wr_data   (wr_data),
        .force_rel (force_rel)
    );

    eal_lock_fsm #(
        .DOM_W (DOM_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lock_hit),
        .req_eal   (wr_data[EAL_LSB +: 2]),
        .req_dom   (wr_dom),
        .force_rel (force_rel),
        .state     (state),
        .owner     (lock_owner)
    );

    eal_desc_bank #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .LOCK_WORD (LOCK_WORD),
        .VLD_WORD  (VLD_WORD),
        .EAL_LSB   (EAL_LSB),
        .VLD_BIT   (VLD_BIT)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .lock_state (state),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .lock_rest  (lock_rest),
        .valid      (desc_valid)
    );

    assign lock_state = state;
endmodule

// File: rtl/eal_lock_chk.sv
`timescale 1ns/1ps
// Module: eal_lock_chk
// Cycle-by-cycle properties of the lock block, attached to the top by bind.
module eal_lock_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 5,
    parameter int DOM_W     = 4,
    parameter int ADDR_W    = 3,
    parameter int LOCK_WORD = 3,
    parameter int VLD_WORD  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_eal,
    input logic              wr_vbit,
    input logic [DOM_W-1:0]  wr_dom,
    input logic [1:0]        lock_state,
    input logic [DOM_W-1:0]  lock_owner,
    input logic              desc_valid,
    input logic              force_rel,
    input logic [DATA_W-1:0] lock_rest
);
    logic in_rng, to_lock, to_vld;
    assign in_rng  = wr_en && ({1'b0, wr_addr} < (ADDR_W+1)'(NUM_WORDS));
    assign to_lock = in_rng && (wr_addr == ADDR_W'(LOCK_WORD));
    assign to_vld  = in_rng && (wr_addr == ADDR_W'(VLD_WORD));

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (lock_state == 2'b00 && lock_owner == '0 && !desc_valid)); // R1

    AST_ZERO_EAL_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (to_lock && wr_eal == 2'b00) |=> ($stable(lock_state) && $stable(lock_owner))); // R2

    AST_NONZERO_EAL_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (to_lock && wr_eal != 2'b00) |=> $stable(lock_rest)); // R3

    AST_NO_RESERVED_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state != 2'b01); // R4

    AST_OWNER_ONLY_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state != 2'b11) |-> (lock_owner == '0)); // R4

    AST_FOREIGN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (to_lock && wr_eal != 2'b00 && !force_rel && lock_state == 2'b11 && wr_dom != lock_owner)
        |=> (lock_state == 2'b11 && $stable(lock_owner))); // R5

    AST_FORCE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        force_rel |=> (lock_state == 2'b10 && lock_owner == '0)); // R6

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rng && !to_vld) |=> !desc_valid); // R10

    AST_VALID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        to_vld |=> (desc_valid == $past(wr_vbit))); // R10
endmodule

bind eal_lock_ctrl eal_lock_chk #(
    .DATA_W    (DATA_W),
    .NUM_WORDS (NUM_WORDS),
    .DOM_W     (DOM_W),
    .ADDR_W    (ADDR_W),
    .LOCK_WORD (LOCK_WORD),
    .VLD_WORD  (VLD_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_eal     (wr_data[EAL_LSB +: 2]),
    .wr_vbit    (wr_data[VLD_BIT]),
    .wr_dom     (wr_dom),
    .lock_state (lock_state),
    .lock_owner (lock_owner),
    .desc_valid (desc_valid),
    .force_rel  (force_rel),
    .lock_rest  (lock_rest)
);

// File: tb/tb_eal_lock_ctrl.sv
`timescale 1ns/1ps
module tb_eal_lock_ctrl;
    localparam logic [31:0] KA = 32'h0200_0046;
    localparam logic [31:0] KB = 32'h0200_0052;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_dom = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  lock_state;
    logic [3:0]  lock_owner;
    logic        desc_valid;

    always #2 clk = ~clk;

    eal_lock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_dom(wr_dom), .rd_addr(rd_addr),
        .rd_data(rd_data), .lock_state(lock_state), .lock_owner(lock_owner),
        .desc_valid(desc_valid)
    );

    typedef struct packed {
        logic [1:0]  st;
        logic [3:0]  own;
        logic        vld;
        logic [31:0] rd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    // Reference model state, written from the requirements.
    logic [31:0] m_w [3];
    logic [31:0] m_rest, m_body;
    logic [1:0]  m_st;
    logic [3:0]  m_own;
    logic        m_vld, m_armed;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        if (a < 3)  return m_w[a];
        if (a == 3) return m_rest | (32'(m_st) << 24);
        if (a == 4) return m_body | (32'(m_vld) << 31);
        return 32'h0;
    endfunction

    task automatic m_step(input bit rst, input bit we, input logic [2:0] a,
                          input logic [31:0] d, input logic [3:0] dom);
        bit hit, lk, frc;
        logic [1:0] e;
        if (rst) begin
            for (int i = 0; i < 3; i++) m_w[i] = '0;
            m_rest = '0; m_body = '0; m_st = 2'b00; m_own = '0;
            m_vld = 1'b0; m_armed = 1'b0;
            return;
        end
        hit = we && (a < 5);
        lk  = hit && (a == 3);
        e   = d[25:24];
        frc = m_armed && lk && (d == KB);
        if (hit) m_armed = lk && (d == KA);
        if (hit && a == 4) begin m_vld = d[31]; m_body = d & 32'h7FFF_FFFF; end
        else if (hit) m_vld = 1'b0;
        if (hit && a < 3) m_w[a] = d;
        if (lk && e == 2'b00) m_rest = d & 32'hFCFF_FFFF;
        if (frc) begin m_st = 2'b10; m_own = '0; end
        else if (lk && e == 2'b10) begin
            if (m_st != 2'b11 || m_own == dom) begin m_st = 2'b10; m_own = '0; end
        end else if (lk && e == 2'b11) begin
            if (m_st != 2'b11) begin m_st = 2'b11; m_own = dom; end
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic op(input bit rst, input bit we, input logic [2:0] a,
                      input logic [31:0] d, input logic [3:0] dom,
                      input logic [2:0] ra, input string tag);
        exp_t x;
        @(negedge clk);
        rst_n = !rst; wr_en = we; wr_addr = a; wr_data = d; wr_dom = dom; rd_addr = ra;
        m_step(rst, we, a, d, dom);
        x.st = m_st; x.own = m_own; x.vld = m_vld; x.rd = m_read(ra);
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] dom,
                      input logic [2:0] ra, input string tag);
        op(1'b0, 1'b1, a, d, dom, ra, tag);
    endtask

    task automatic idle(input logic [2:0] ra, input string tag);
        op(1'b0, 1'b0, 3'd0, 32'h0, 4'd0, ra, tag);
    endtask

    // Monitor: compares outputs just after the edge that applied each item.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            exp_t  x;
            string t;
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (lock_state !== x.st || lock_owner !== x.own ||
                desc_valid !== x.vld || rd_data !== x.rd) begin
                failures++;
                $display("FAIL %s: actual st=%b own=%0d vld=%b rd=%h expected st=%b own=%0d vld=%b rd=%h",
                         t, lock_state, lock_owner, desc_valid, rd_data,
                         x.st, x.own, x.vld, x.rd);
            end
        end
    end

    initial begin
        // R1: reset state
        op(1'b1, 1'b0, 3'd0, 32'h0, 4'd0, 3'd3, "R1 reset lock word");
        op(1'b1, 1'b0, 3'd0, 32'h0, 4'd0, 3'd4, "R1 reset valid word");
        // R11 / R10: plain and valid words
        wr(3'd0, 32'hA5A5_0001, 4'd1, 3'd0, "R11 plain word 0");
        wr(3'd2, 32'h1357_9BDF, 4'd1, 3'd2, "R11 plain word 2");
        wr(3'd4, 32'h8000_1234, 4'd1, 3'd4, "R10 valid set");
        wr(3'd1, 32'h0000_00FF, 4'd1, 3'd4, "R10 valid cleared by word 1");
        wr(3'd4, 32'h8000_1234, 4'd1, 3'd4, "R10 valid set again");
        wr(3'd4, 32'h0000_5678, 4'd1, 3'd4, "R10 valid loaded with 0");
        wr(3'd4, 32'hFFFF_FFFF, 4'd1, 3'd4, "R11 valid word readback");
        // R2: zero lock field updates other bits only
        wr(3'd3, 32'h00FF_00C3, 4'd1, 3'd3, "R2 zero lock field write");
        // R3 / R4: non-zero lock field
        wr(3'd3, 32'h5A00_0011, 4'd1, 3'd3, "R3 R4 enable to available");
        wr(3'd3, 32'h0100_0000, 4'd1, 3'd3, "R4 reserved ignored");
        wr(3'd3, 32'h0300_0000, 4'd3, 3'd3, "R4 domain 3 takes lock");
        wr(3'd3, 32'h0200_0000, 4'd5, 3'd3, "R5 foreign release blocked");
        wr(3'd3, 32'h0300_0000, 4'd5, 3'd3, "R5 foreign take blocked");
        wr(3'd3, 32'h00AB_0000, 4'd5, 3'd3, "R2 field write while held");
        // R9: lone second key
        wr(3'd3, KB, 4'd5, 3'd3, "R9 lone second key");
        // R6 / R7: forced release with idle gap
        wr(3'd4, 32'h8000_0000, 4'd5, 3'd4, "R10 valid set before keys");
        wr(3'd3, KA, 4'd5, 3'd4, "R10 key write clears valid");
        idle(3'd3, "R6 idle between keys");
        wr(3'd3, KB, 4'd5, 3'd3, "R6 R7 forced release");
        // R4: owner release
        wr(3'd3, 32'h0300_0000, 4'd3, 3'd3, "R4 domain 3 takes again");
        wr(3'd3, 32'h0200_0000, 4'd3, 3'd3, "R4 owner release");
        // R8: intervening write to another word
        wr(3'd3, 32'h0300_0000, 4'd7, 3'd3, "R4 domain 7 takes lock");
        wr(3'd3, KA, 4'd5, 3'd3, "R8 first key");
        wr(3'd0, 32'h0000_BEEF, 4'd5, 3'd0, "R8 intervening word 0 write");
        wr(3'd3, KB, 4'd5, 3'd3, "R8 second key after intervening");
        // R8: intervening zero lock-field write to the lock word
        wr(3'd3, KA, 4'd5, 3'd3, "R8 first key again");
        wr(3'd3, 32'h0000_0077, 4'd5, 3'd3, "R8 intervening lock word write");
        wr(3'd3, KB, 4'd5, 3'd3, "R8 second key after lock write");
        // R8: repeated first key stays armed
        wr(3'd3, KA, 4'd5, 3'd3, "R8 first key once");
        wr(3'd3, KA, 4'd5, 3'd3, "R8 first key repeated");
        wr(3'd3, KB, 4'd5, 3'd3, "R8 R7 release after repeated key");
        // R11: out-of-range writes ignored
        wr(3'd4, 32'h8000_0001, 4'd1, 3'd4, "R11 valid set");
        wr(3'd6, 32'hFFFF_FFFF, 4'd1, 3'd6, "R11 out of range reads 0");
        wr(3'd7, 32'hFFFF_FFFF, 4'd1, 3'd4, "R11 out of range keeps valid");
        // R4: take from disabled after reset, then reset mid-run
        op(1'b1, 1'b0, 3'd0, 32'h0, 4'd0, 3'd0, "R1 reset clears word 0");
        wr(3'd3, 32'h0300_0000, 4'd9, 3'd3, "R4 take from disabled");
        op(1'b1, 1'b0, 3'd0, 32'h0, 4'd0, 3'd3, "R1 reset drops lock");
        wr(3'd3, KB, 4'd2, 3'd3, "R1 detector idle after reset");
        idle(3'd3, "final");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule